// File: doc/BRIEF.md
# Rational-Period Precision Time Counter

This block keeps a free-running time of day for precision time protocol hardware: a nanoseconds count that rolls over once per second and a 48-bit seconds count. On every cycle of its input clock the time moves forward by a programmable period. The period is a whole number of nanoseconds plus a rational fraction, numerator over denominator. A fractional accumulator spreads the extra nanoseconds so that, over many cycles, the average advance is exact. For example, a 2.5 ns period is a whole part of 2 with a numerator equal to half the denominator.

Software drives the block through a plain write strobe with address and data. Period fields, an absolute time and a signed step are first written to shadow registers. Each group then takes effect only when its own commit word is written. Nonsensical values are refused at commit: a zero denominator, a numerator that is not below the denominator, or a load nanoseconds value of a full second or more. Reads are registered. Reading the nanoseconds word freezes a copy of the seconds, so a three-word read returns one coherent instant even when a second boundary falls between the reads. The live time is also driven on dedicated outputs for capture logic next to the block.

Top module: `ptp_rational_clock`

## Requirements
- R1: After reset, the time is 0 s 0 ns, the live period is whole part 4, numerator 0, denominator 1, all shadows are 0, and rdValid is low.
- R2: On every cycle without a load, the nanoseconds advance by the whole part plus one extra nanosecond when the accumulator overflows. The accumulator adds the numerator each cycle, and when the sum reaches the denominator it subtracts the denominator and grants the extra nanosecond.
- R3: Writes to address 0x0 (whole part), 0x1 (numerator) and 0x2 (denominator) only change shadows. A write of 0x3 with data bit 0 set copies all three to the live period at that edge and clears the accumulator. That edge still uses the old period, and the new one applies from the next cycle.
- R4: A period commit is refused, leaving the live period unchanged, when the shadow denominator is 0 or the shadow numerator is not below it.
- R5: The whole part keeps only its low 8 bits; higher bits written to address 0x0 are dropped.
- R6: When the nanoseconds reach 1,000,000,000 they wrap, and 1 carries into the 48-bit seconds, including across the 32-bit word boundary.
- R7: Address 0x4 (nanoseconds, bits 29:0), 0x5 (seconds bits 47:32) and 0x6 (seconds bits 31:0) fill load shadows. A write of 0x7 with bit 0 set replaces the time with them at that edge, instead of that cycle's advance. The load is refused if the shadow nanoseconds are 1,000,000,000 or more.
- R8: Address 0x8 holds a step word: magnitude in bits 29:0, negative flag in bit 31, bit 30 ignored. A write of 0x9 with bit 0 set adds or subtracts the magnitude on top of that cycle's normal advance.
- R9: A step that leaves the nanoseconds outside 0 to 999,999,999 is normalised by carrying or borrowing one or two seconds.
- R10: A read with rdEn high returns rdData with rdValid high on the next cycle. Address 0x0, 0x1 and 0x2 give the live period fields, and 0xA gives the current nanoseconds.
- R11: A read of 0xA also latches the seconds. Addresses 0xB (bits 47:32) and 0xC (bits 31:0) return that latched copy until the next read of 0xA.
- R12: A write to any commit address (0x3, 0x7, 0x9) with data bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 4 | Read address |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| rdValid | output | 1 | rdData holds the result of the previous read |
| nowNs | output | 30 | Live nanoseconds |
| nowSec | output | 48 | Live seconds |

## Verification
A wrong accumulator or period register shows at nowNs within one cycle, because every cycle's advance is compared against an independent model. A lost fractional carry appears as soon as enough cycles have passed for the fraction to sum to one nanosecond. A broken wrap or borrow shows on nowSec in the very cycle the boundary is crossed, whether from the normal advance, a load or a step. Shadow leaks or a refused commit that slipped through show immediately on the period read-back and on the next cycle's nowNs. A seconds snapshot taken at the wrong time only shows at rdData when a later seconds read follows a second boundary, so the bench arranges that case on purpose.

// File: rtl/ptpclk_pkg.sv
package ptpclk_pkg;

  typedef enum logic [3:0] {
    REG_PER_WHOLE  = 4'h0,
    REG_PER_NUM    = 4'h1,
    REG_PER_DEN    = 4'h2,
    REG_PER_GO     = 4'h3,
    REG_SET_NS     = 4'h4,
    REG_SET_SEC_HI = 4'h5,
    REG_SET_SEC_LO = 4'h6,
    REG_SET_GO     = 4'h7,
    REG_STEP       = 4'h8,
    REG_STEP_GO    = 4'h9,
    REG_NOW_NS     = 4'hA,
    REG_NOW_SEC_HI = 4'hB,
    REG_NOW_SEC_LO = 4'hC
  } regAddr_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic periodGo;
    logic loadGo;
    logic stepGo;
    logic snapGo;
  } ctlStrobe_t;

  localparam int STEP_NEG_BIT = 31;

endpackage

// File: rtl/ptpclk_ctrl.sv
module ptpclk_ctrl
  import ptpclk_pkg::*;
#(
  parameter int QUO_W      = 8,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  parameter int DATA_W     = 32,
  localparam int NS_W      = $clog2(NS_PER_SEC),
  localparam int SEC_HI_W  = SEC_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [3:0]        rdAddr,
  input  logic [QUO_W-1:0]  liveQuo,
  input  logic [FRAC_W-1:0] liveNum,
  input  logic [FRAC_W-1:0] liveDen,
  input  logic [NS_W-1:0]   nowNs,
  input  logic [SEC_W-1:0]  snapSec,
  output ctlStrobe_t        strb,
  output logic [QUO_W-1:0]  shQuo,
  output logic [FRAC_W-1:0] shNum,
  output logic [FRAC_W-1:0] shDen,
  output logic [NS_W-1:0]   shNs,
  output logic [SEC_W-1:0]  shSec,
  output logic [NS_W-1:0]   shStepMag,
  output logic              shStepNeg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(NS_PER_SEC);

  logic periodOk;
  logic loadOk;
  logic [DATA_W-1:0] rdMux;

  // a commit is refused when the shadows describe an impossible setting
  assign periodOk = (shDen != '0) && (shNum < shDen);
  assign loadOk   = ({1'b0, shNs} < NS_LIMIT);

  always_comb begin
    strb          = '0;
    strb.periodGo = wrEn && (wrAddr == REG_PER_GO)  && wrData[0] && periodOk;
    strb.loadGo   = wrEn && (wrAddr == REG_SET_GO)  && wrData[0] && loadOk;
    strb.stepGo   = wrEn && (wrAddr == REG_STEP_GO) && wrData[0];
    strb.snapGo   = rdEn && (rdAddr == REG_NOW_NS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQuo     <= '0;
      shNum     <= '0;
      shDen     <= '0;
      shNs      <= '0;
      shSec     <= '0;
      shStepMag <= '0;
      shStepNeg <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_PER_WHOLE:  shQuo <= wrData[QUO_W-1:0];
        REG_PER_NUM:    shNum <= wrData[FRAC_W-1:0];
        REG_PER_DEN:    shDen <= wrData[FRAC_W-1:0];
        REG_SET_NS:     shNs  <= wrData[NS_W-1:0];
        REG_SET_SEC_HI: shSec[SEC_W-1:DATA_W] <= wrData[SEC_HI_W-1:0];
        REG_SET_SEC_LO: shSec[DATA_W-1:0]     <= wrData;
        REG_STEP: begin
          shStepMag <= wrData[NS_W-1:0];
          shStepNeg <= wrData[STEP_NEG_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rdAddr)
      REG_PER_WHOLE:  rdMux = DATA_W'(liveQuo);
      REG_PER_NUM:    rdMux = DATA_W'(liveNum);
      REG_PER_DEN:    rdMux = DATA_W'(liveDen);
      REG_NOW_NS:     rdMux = DATA_W'(nowNs);
      REG_NOW_SEC_HI: rdMux = DATA_W'(snapSec[SEC_W-1:DATA_W]);
      REG_NOW_SEC_LO: rdMux = snapSec[DATA_W-1:0];
      default:        rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/ptpclk_core.sv
module ptpclk_core
  import ptpclk_pkg::*;
#(
  parameter int QUO_W      = 8,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  parameter int RST_QUO    = 4,
  localparam int NS_W      = $clog2(NS_PER_SEC),
  localparam int SW        = NS_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [QUO_W-1:0]  shQuo,
  input  logic [FRAC_W-1:0] shNum,
  input  logic [FRAC_W-1:0] shDen,
  input  logic [NS_W-1:0]   shNs,
  input  logic [SEC_W-1:0]  shSec,
  input  logic [NS_W-1:0]   shStepMag,
  input  logic              shStepNeg,
  output logic [QUO_W-1:0]  liveQuo,
  output logic [FRAC_W-1:0] liveNum,
  output logic [FRAC_W-1:0] liveDen,
  output logic [NS_W-1:0]   nowNs,
  output logic [SEC_W-1:0]  nowSec,
  output logic [SEC_W-1:0]  snapSec
);

  localparam logic signed [SW-1:0] ONE_SEC = SW'(64'(NS_PER_SEC));
  localparam logic signed [SW-1:0] TWO_SEC = SW'(64'(NS_PER_SEC) * 2);

  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic              extraNs;
  logic [FRAC_W-1:0] fracNext;

  logic signed [SW-1:0] magWide;
  logic signed [SW-1:0] stepDelta;
  logic signed [SW-1:0] rawNs;
  logic signed [SW-1:0] normNs;
  logic signed [2:0]    secMove;
  logic [NS_W-1:0]      nsNext;
  logic [SEC_W-1:0]     secNext;

  // fractional accumulator: one extra nanosecond per overflow
  always_comb begin
    fracSum  = {1'b0, fracAcc} + {1'b0, liveNum};
    extraNs  = (fracSum >= {1'b0, liveDen});
    fracNext = extraNs ? FRAC_W'(fracSum - {1'b0, liveDen}) : FRAC_W'(fracSum);
  end

  // one adder chain serves the tick and an optional signed step
  always_comb begin
    magWide   = SW'(shStepMag);
    if (!strb.stepGo)   stepDelta = '0;
    else if (shStepNeg) stepDelta = -magWide;
    else                stepDelta = magWide;
    rawNs = SW'(nowNs) + SW'(liveQuo) + SW'(extraNs) + stepDelta;

    if (rawNs >= TWO_SEC) begin
      normNs  = rawNs - TWO_SEC;
      secMove = 3'sd2;
    end else if (rawNs >= ONE_SEC) begin
      normNs  = rawNs - ONE_SEC;
      secMove = 3'sd1;
    end else if (rawNs < -ONE_SEC) begin
      normNs  = rawNs + TWO_SEC;
      secMove = -3'sd2;
    end else if (rawNs < 0) begin
      normNs  = rawNs + ONE_SEC;
      secMove = -3'sd1;
    end else begin
      normNs  = rawNs;
      secMove = 3'sd0;
    end
    nsNext  = NS_W'(normNs);
    secNext = nowSec + {{(SEC_W-3){secMove[2]}}, secMove};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQuo <= QUO_W'(RST_QUO);
      liveNum <= '0;
      liveDen <= FRAC_W'(1);
      fracAcc <= '0;
    end else if (strb.periodGo) begin
      liveQuo <= shQuo;
      liveNum <= shNum;
      liveDen <= shDen;
      fracAcc <= '0;
    end else begin
      fracAcc <= fracNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowNs  <= '0;
      nowSec <= '0;
    end else if (strb.loadGo) begin
      nowNs  <= shNs;
      nowSec <= shSec;
    end else begin
      nowNs  <= nsNext;
      nowSec <= secNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            snapSec <= '0;
    else if (strb.snapGo) snapSec <= nowSec;
  end

endmodule

// File: rtl/ptp_rational_clock.sv
module ptp_rational_clock
  import ptpclk_pkg::*;
#(
  parameter int QUO_W      = 8,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  parameter int RST_QUO    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [3:0]                     wrAddr,
  input  logic [31:0]                    wrData,
  input  logic                           rdEn,
  input  logic [3:0]                     rdAddr,
  output logic [31:0]                    rdData,
  output logic                           rdValid,
  output logic [$clog2(NS_PER_SEC)-1:0]  nowNs,
  output logic [SEC_W-1:0]               nowSec
);

  localparam int NS_W = $clog2(NS_PER_SEC);

  ctlStrobe_t        strb;
  logic [QUO_W-1:0]  shQuo, liveQuo;
  logic [FRAC_W-1:0] shNum, shDen, liveNum, liveDen;
  logic [NS_W-1:0]   shNs, shStepMag;
  logic [SEC_W-1:0]  shSec, snapSec;
  logic              shStepNeg;

  ptpclk_ctrl #(
    .QUO_W(QUO_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W),
    .NS_PER_SEC(NS_PER_SEC), .DATA_W(32)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .liveQuo(liveQuo), .liveNum(liveNum), .liveDen(liveDen),
    .nowNs(nowNs), .snapSec(snapSec),
    .strb(strb),
    .shQuo(shQuo), .shNum(shNum), .shDen(shDen),
    .shNs(shNs), .shSec(shSec),
    .shStepMag(shStepMag), .shStepNeg(shStepNeg),
    .rdData(rdData), .rdValid(rdValid)
  );

  ptpclk_core #(
    .QUO_W(QUO_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W),
    .NS_PER_SEC(NS_PER_SEC), .RST_QUO(RST_QUO)
  ) u_core (
    .clk(clk), .rstN(rstN), .strb(strb),
    .shQuo(shQuo), .shNum(shNum), .shDen(shDen),
    .shNs(shNs), .shSec(shSec),
    .shStepMag(shStepMag), .shStepNeg(shStepNeg),
    .liveQuo(liveQuo), .liveNum(liveNum), .liveDen(liveDen),
    .nowNs(nowNs), .nowSec(nowSec), .snapSec(snapSec)
  );

endmodule

// File: rtl/ptpclk_checker.sv
module ptpclk_checker
  import ptpclk_pkg::*;
#(
  parameter int QUO_W      = 8,
  parameter int FRAC_W     = 32,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  localparam int NS_W      = $clog2(NS_PER_SEC)
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              rdValid,
  input ctlStrobe_t        strb,
  input logic [QUO_W-1:0]  liveQuo,
  input logic [FRAC_W-1:0] liveNum,
  input logic [FRAC_W-1:0] liveDen,
  input logic [NS_W-1:0]   nowNs,
  input logic [SEC_W-1:0]  nowSec
);

  // R10: read result follows the strobe by one cycle
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R4: the live period is always a legal fraction
  a_r4_legal_period: assert property (@(posedge clk) disable iff (!rstN)
    (liveDen != '0) && (liveNum < liveDen));

  // R3: the live period only moves on an accepted commit
  a_r3_period_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodGo |=> ($stable(liveQuo) && $stable(liveNum) && $stable(liveDen)));

  // R6: nanoseconds stay below one second
  a_r6_ns_range: assert property (@(posedge clk) disable iff (!rstN)
    {2'b00, nowNs} < (NS_W+2)'(NS_PER_SEC));

  // R2: with no load or step the time never goes backwards and moves by at most one second
  a_r2_forward: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadGo || strb.stepGo) |=>
      ((nowSec == $past(nowSec)) && (nowNs >= $past(nowNs))) ||
      ((nowSec == $past(nowSec) + 1'b1) && (nowNs < $past(nowNs))));

endmodule

bind ptp_rational_clock ptpclk_checker #(
  .QUO_W(QUO_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdValid(rdValid), .strb(strb),
  .liveQuo(liveQuo), .liveNum(liveNum), .liveDen(liveDen),
  .nowNs(nowNs), .nowSec(nowSec)
);

// File: tb/ptp_rational_clock_bench.sv
`timescale 1ns/1ps
module ptp_rational_clock_bench;

  localparam longint NSS = 1000000000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [29:0] nowNs;
  logic [47:0] nowSec;

  int checks = 0;
  int errors = 0;
  bit liveCheck = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ptp_rational_clock u_ptp_rational_clock (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .nowNs(nowNs), .nowSec(nowSec)
  );

  // ---------------- reference model built from the requirements ----------
  longint mQuo, mNum, mDen, mAcc, mNs, mSec, mSnap;
  longint sQuo, sNum, sDen, sNs, sSec, sMag;
  bit     sNeg;

  always @(posedge clk) begin
    longint sum, t;
    bit extra, pGo, lGo, sGo;
    if (!rstN) begin
      mQuo = 4; mNum = 0; mDen = 1; mAcc = 0; mNs = 0; mSec = 0; mSnap = 0;
      sQuo = 0; sNum = 0; sDen = 0; sNs = 0; sSec = 0; sMag = 0; sNeg = 0;
    end else begin
      pGo = wrEn && wrAddr == 4'h3 && wrData[0] && sDen != 0 && sNum < sDen;
      lGo = wrEn && wrAddr == 4'h7 && wrData[0] && sNs < NSS;
      sGo = wrEn && wrAddr == 4'h9 && wrData[0];
      if (rdEn && rdAddr == 4'hA) mSnap = mSec;
      sum = mAcc + mNum;
      extra = (sum >= mDen);
      mAcc = extra ? sum - mDen : sum;
      t = mNs + mQuo + longint'(extra);
      if (sGo) t = sNeg ? t - sMag : t + sMag;
      if (lGo) begin
        mNs = sNs; mSec = sSec;
      end else begin
        while (t >= NSS) begin t = t - NSS; mSec = mSec + 1; end
        while (t < 0)    begin t = t + NSS; mSec = mSec - 1; end
        mNs = t;
        mSec = mSec & SEC_MASK;
      end
      if (pGo) begin mQuo = sQuo; mNum = sNum; mDen = sDen; mAcc = 0; end
      if (wrEn) begin
        case (wrAddr)
          4'h0: sQuo = longint'(wrData[7:0]);
          4'h1: sNum = longint'(wrData);
          4'h2: sDen = longint'(wrData);
          4'h4: sNs  = longint'(wrData[29:0]);
          4'h5: sSec = (sSec & 64'hFFFF_FFFF) | (longint'(wrData[15:0]) << 32);
          4'h6: sSec = (sSec & ~64'hFFFF_FFFF) | longint'(wrData);
          4'h8: begin sMag = longint'(wrData[29:0]); sNeg = wrData[31]; end
          default: ;
        endcase
      end
    end
  end

  // ---------------- scoreboard -------------------------------------------
  longint expQ[$];
  string  tagQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares read results and the live time outputs
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected read result", longint'(rdData), -1);
      end else begin
        longint e;
        string  g;
        e = expQ.pop_front();
        g = tagQ.pop_front();
        check(longint'(rdData) == e, g, longint'(rdData), e);
      end
    end
    if (rstN && liveCheck) begin
      check(longint'(nowNs) == mNs, "R2 live nanoseconds", longint'(nowNs), mNs);
      check(longint'(nowSec) == mSec, "R6 live seconds", longint'(nowSec), mSec);
    end
  end

  // driver tasks, entered at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    longint e;
    case (a)
      4'h0: e = mQuo;
      4'h1: e = mNum;
      4'h2: e = mDen;
      4'hA: e = mNs;
      4'hB: e = (mSnap >> 32) & 64'hFFFF;
      4'hC: e = mSnap & 64'hFFFF_FFFF;
      default: e = 0;
    endcase
    rdEn = 1'b1; rdAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadTime(input logic [31:0] ns, input logic [15:0] hi, input logic [31:0] lo);
    wr(4'h4, ns); wr(4'h5, {16'h0, hi}); wr(4'h6, lo); wr(4'h7, 32'h1);
  endtask

  task automatic stepTime(input logic [31:0] word);
    wr(4'h8, word); wr(4'h9, 32'h1);
  endtask

  task automatic setPeriod(input logic [31:0] q, input logic [31:0] n, input logic [31:0] d);
    wr(4'h0, q); wr(4'h1, n); wr(4'h2, d); wr(4'h3, 32'h1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state before the first active edge
    check(nowNs == 0, "R1 reset nanoseconds", longint'(nowNs), 0);
    check(nowSec == 0, "R1 reset seconds", longint'(nowSec), 0);
    check(rdValid == 1'b0, "R1 reset rdValid", longint'(rdValid), 0);
    liveCheck = 1'b1;
    rd(4'h0, "R1 R10 reset whole part");
    rd(4'h1, "R1 R10 reset numerator");
    rd(4'h2, "R1 R10 reset denominator");
    idle(10);
    rd(4'hA, "R2 default period advance");

    // R3: shadow write alone changes nothing
    wr(4'h0, 32'd7);
    idle(3);
    rd(4'h0, "R3 shadow not yet live");
    rd(4'hA, "R3 time still on old period");

    // R2 R3: 2.5 ns period
    setPeriod(32'd2, 32'd1, 32'd2);
    rd(4'h0, "R3 committed whole part");
    rd(4'h1, "R3 committed numerator");
    rd(4'h2, "R3 committed denominator");
    idle(9);
    rd(4'hA, "R2 half-nanosecond fraction");
    // R2: one third fraction
    setPeriod(32'd3, 32'd1, 32'd3);
    for (int i = 0; i < 4; i++) begin
      idle(i + 1);
      rd(4'hA, "R2 one-third fraction");
    end

    // R4: refused commits
    wr(4'h2, 32'd0); wr(4'h3, 32'h1);
    rd(4'h2, "R4 zero denominator refused");
    wr(4'h1, 32'd5); wr(4'h2, 32'd5); wr(4'h3, 32'h1);
    rd(4'h1, "R4 numerator equal to denominator refused");
    idle(2);
    rd(4'hA, "R4 time keeps old period");

    // R5: whole part masked to 8 bits
    setPeriod(32'h0001_FF05, 32'd0, 32'd1);
    rd(4'h0, "R5 whole part masked");

    // R12: commits with bit 0 clear
    wr(4'h0, 32'd9); wr(4'h3, 32'h0);
    rd(4'h0, "R12 period commit with bit0 clear");
    wr(4'h4, 32'd123); wr(4'h7, 32'hFFFF_FFFE);
    rd(4'hA, "R12 load commit with bit0 clear");
    wr(4'h8, 32'd500); wr(4'h9, 32'h2);
    rd(4'hA, "R12 step commit with bit0 clear");
    wr(4'h0, 32'd5); // restore shadow whole part

    // R7 R6: load near a boundary, carry across 32-bit seconds word
    loadTime(32'd999_999_950, 16'h0001, 32'hFFFF_FFFF);
    rd(4'hA, "R7 loaded nanoseconds");
    idle(12);
    rd(4'hA, "R6 wrapped nanoseconds");
    rd(4'hB, "R6 seconds high after carry");
    rd(4'hC, "R6 seconds low after carry");

    // R7: nanoseconds of a full second refused
    loadTime(32'd1_000_000_000, 16'h0, 32'd77);
    rd(4'hA, "R7 out of range load refused");

    // R8 R9: steps
    loadTime(32'd1000, 16'h0, 32'd20);
    stepTime(32'd100);
    rd(4'hA, "R8 positive step");
    stepTime(32'h8000_0032);
    rd(4'hA, "R8 negative step");
    stepTime(32'h4000_0014);
    rd(4'hA, "R8 bit 30 ignored");
    loadTime(32'd10, 16'h0, 32'd5);
    stepTime(32'h8000_03E8);
    rd(4'hA, "R9 negative step borrows");
    rd(4'hC, "R9 seconds after borrow");
    stepTime(32'h3FFF_FFFF);
    rd(4'hA, "R9 large positive step");
    rd(4'hC, "R9 seconds after double carry");
    loadTime(32'd0, 16'h0, 32'd9);
    stepTime(32'hBFFF_FFFF);
    rd(4'hA, "R9 large negative step");
    rd(4'hC, "R9 seconds after double borrow");

    // R11: snapshot survives a second boundary
    loadTime(32'd999_999_900, 16'h0002, 32'd7);
    rd(4'hA, "R11 nanoseconds snapshot");
    idle(30);
    rd(4'hC, "R11 latched seconds low");
    rd(4'hB, "R11 latched seconds high");
    rd(4'hA, "R11 new snapshot");
    rd(4'hC, "R11 refreshed seconds low");

    idle(3);
    check(expQ.size() == 0, "R10 all reads answered", longint'(expQ.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule